// File: doc/BRIEF.md
# Sector-Aligned Read Request Splitter

This block accepts a read request made of a starting word offset and a word count, and turns it into a series of smaller read requests that each stay inside one sector of the backing memory. Each sub-request carries a byte offset and a byte length, which are twice the word values. The final sub-request of a sequence is marked as last.

The block waits for an acknowledge after each sub-request before it issues the next one. If the first chunk starts partway into a sector, it is cut short so that it ends at the sector boundary. Every later chunk is a full sector, except that the last chunk holds only the words that remain.

A request that would read past the end of memory is refused before any sub-request goes out. A failed acknowledge stops the sequence. Either way, one completion pulse reports a status and the number of words that were read successfully.

Top module: `sector_read_splitter`

## Requirements
- R1: After reset, cmd_ready is 1, sub_valid is 0 and done_valid is 0.
- R2: The word length of each chunk is the smaller of two values: the words still remaining, and the words from the current offset up to the next multiple of SECTOR_WORDS. A request that starts on a sector boundary is therefore served in full sectors until the last chunk.
- R3: No sub-request crosses a sector boundary. Every sub-request length is at least 1 word and at most SECTOR_WORDS words.
- R4: sub_byte_off equals twice the current word offset, and sub_byte_len equals twice the chunk word length. Both are therefore always even.
- R5: sub_last is 1 on the final sub-request of a request and 0 on every sub-request before it.
- R6: A sub-request stays valid, with unchanged fields, until sub_ready accepts it. The next sub-request is not issued until an acknowledge for the current one arrives.
- R7: An acknowledge with ack_err = 1 ends the sequence. done_status is then 2 and done_words is the sum of the chunks acknowledged without error.
- R8: A request whose offset plus count exceeds MEM_WORDS issues no sub-request. The next cycle after acceptance it completes with done_status 1 and done_words 0. A request that ends exactly at MEM_WORDS is accepted.
- R9: A zero word count issues no sub-request. The next cycle after acceptance it completes with done_status 0 and done_words 0.
- R10: A fully successful request completes with done_status 0 and done_words equal to the requested count. done_valid is a single-cycle pulse.
- R11: cmd_ready is 0 from the moment a request is accepted until its completion. An acknowledge that arrives while no sub-request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A read request is offered |
| cmd_ready | output | 1 | The block is idle and takes a request |
| cmd_offset | input | AW | Start word offset |
| cmd_count | input | AW+1 | Number of words to read |
| sub_valid | output | 1 | A sub-request is offered |
| sub_ready | input | 1 | Downstream takes the sub-request |
| sub_byte_off | output | AW+1 | Sub-request byte offset |
| sub_byte_len | output | LW+1 | Sub-request byte length |
| sub_last | output | 1 | Final sub-request of the request |
| ack_valid | input | 1 | Completion of the outstanding sub-request |
| ack_err | input | 1 | The sub-request failed |
| done_valid | output | 1 | One-cycle completion pulse |
| done_words | output | AW+1 | Words completed successfully |
| done_status | output | 2 | Completion status: 0 ok, 1 out of range, 2 sub-request failure |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of bug:
- Unaligned starts must produce a short first chunk. A wrong remainder calculation would either cross a sector or leave gaps.
- A request that ends exactly on a boundary must yield one chunk flagged last. An off-by-one here would produce a zero-length tail or drop the flag.
- A request ending exactly at the memory limit must be accepted, while one word more must be refused. A wrong comparison would flip one of the two.

Failures on the first chunk and on a middle chunk check the completed-word count. A design that adds the failed chunk to the count, or never stops, would report the wrong total. Stalled ready, delayed acknowledges and a stray acknowledge with no sub-request outstanding check that the sequence does not skip ahead.

// File: rtl/sector_split_pkg.sv
package sector_split_pkg;

    typedef enum logic [1:0] {
        SPL_OK    = 2'd0,
        SPL_RANGE = 2'd1,
        SPL_FAIL  = 2'd2
    } spl_status_e;

    typedef enum logic [1:0] {
        SPL_IDLE  = 2'd0,
        SPL_ISSUE = 2'd1,
        SPL_WAIT  = 2'd2
    } spl_state_e;

    // Words left in the current sector from a word offset within it.
    function automatic int unsigned room_in_sector(int unsigned in_sec, int unsigned sector);
        return sector - in_sec;
    endfunction

endpackage

// File: rtl/spl_range_guard.sv
module spl_range_guard #(
    parameter int MEM_WORDS = 32768,
    parameter int AW        = $clog2(MEM_WORDS),
    parameter int CW        = AW + 1
) (
    input  logic [AW-1:0] offset,
    input  logic [CW-1:0] count,
    output logic          out_of_range
);
    localparam logic [CW:0] LIMIT = (CW+1)'(MEM_WORDS);

    logic [CW:0] end_excl;

    always_comb begin
        end_excl     = (CW+1)'(offset) + (CW+1)'(count);
        out_of_range = end_excl > LIMIT;
    end
endmodule

// File: rtl/spl_chunk_calc.sv
module spl_chunk_calc
    import sector_split_pkg::*;
#(
    parameter int SECTOR_WORDS = 2048,
    parameter int AW           = 15,
    parameter int CW           = AW + 1,
    parameter int SW           = $clog2(SECTOR_WORDS),
    parameter int LW           = SW + 1
) (
    input  logic [AW-1:0] cur_off,
    input  logic [CW-1:0] remain,
    output logic [LW-1:0] len_words,
    output logic          is_last
);
    logic [LW-1:0] room;

    always_comb begin
        room = LW'(room_in_sector(int'(cur_off[SW-1:0]), SECTOR_WORDS));
        if (remain <= CW'(room)) begin
            len_words = remain[LW-1:0];
            is_last   = 1'b1;
        end else begin
            len_words = room;
            is_last   = 1'b0;
        end
    end
endmodule

// File: rtl/sector_read_splitter.sv
module sector_read_splitter
    import sector_split_pkg::*;
#(
    parameter int SECTOR_WORDS = 2048,
    parameter int MEM_WORDS    = 32768,
    parameter int AW           = $clog2(MEM_WORDS),
    parameter int SW           = $clog2(SECTOR_WORDS),
    parameter int LW           = SW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_offset,
    input  logic [AW:0]   cmd_count,
    output logic          sub_valid,
    input  logic          sub_ready,
    output logic [AW:0]   sub_byte_off,
    output logic [LW:0]   sub_byte_len,
    output logic          sub_last,
    input  logic          ack_valid,
    input  logic          ack_err,
    output logic          done_valid,
    output logic [AW:0]   done_words,
    output logic [1:0]    done_status
);
    localparam int CW = AW + 1;

    spl_state_e    state;
    spl_status_e   status_q;
    logic [AW-1:0] cur_off;
    logic [CW-1:0] remain;
    logic [CW-1:0] done_cnt;
    logic [LW-1:0] pend_len;
    logic          pend_last;

    logic          oor;
    logic [LW-1:0] len_w;
    logic          last_w;

    spl_range_guard #(.MEM_WORDS(MEM_WORDS), .AW(AW), .CW(CW)) u_guard (
        .offset       (cmd_offset),
        .count        (cmd_count),
        .out_of_range (oor)
    );

    spl_chunk_calc #(.SECTOR_WORDS(SECTOR_WORDS), .AW(AW), .CW(CW), .SW(SW), .LW(LW)) u_chunk (
        .cur_off   (cur_off),
        .remain    (remain),
        .len_words (len_w),
        .is_last   (last_w)
    );

    assign cmd_ready    = (state == SPL_IDLE);
    assign sub_valid    = (state == SPL_ISSUE);
    assign sub_byte_off = {cur_off, 1'b0};
    assign sub_byte_len = {len_w, 1'b0};
    assign sub_last     = last_w;
    assign done_status  = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SPL_IDLE;
            status_q   <= SPL_OK;
            cur_off    <= '0;
            remain     <= '0;
            done_cnt   <= '0;
            pend_len   <= '0;
            pend_last  <= 1'b0;
            done_valid <= 1'b0;
            done_words <= '0;
        end else begin
            done_valid <= 1'b0;
            case (state)
                SPL_IDLE: begin
                    if (cmd_valid) begin
                        if (oor) begin
                            done_valid <= 1'b1;
                            status_q   <= SPL_RANGE;
                            done_words <= '0;
                        end else if (cmd_count == '0) begin
                            done_valid <= 1'b1;
                            status_q   <= SPL_OK;
                            done_words <= '0;
                        end else begin
                            state    <= SPL_ISSUE;
                            cur_off  <= cmd_offset;
                            remain   <= cmd_count;
                            done_cnt <= '0;
                        end
                    end
                end
                SPL_ISSUE: begin
                    if (sub_ready) begin
                        pend_len  <= len_w;
                        pend_last <= last_w;
                        state     <= SPL_WAIT;
                    end
                end
                SPL_WAIT: begin
                    if (ack_valid) begin
                        if (ack_err) begin
                            done_valid <= 1'b1;
                            status_q   <= SPL_FAIL;
                            done_words <= done_cnt;
                            state      <= SPL_IDLE;
                        end else begin
                            done_cnt <= done_cnt + CW'(pend_len);
                            cur_off  <= cur_off + AW'(pend_len);
                            remain   <= remain - CW'(pend_len);
                            if (pend_last) begin
                                done_valid <= 1'b1;
                                status_q   <= SPL_OK;
                                done_words <= done_cnt + CW'(pend_len);
                                state      <= SPL_IDLE;
                            end else begin
                                state <= SPL_ISSUE;
                            end
                        end
                    end
                end
                default: state <= SPL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
    parameter int SECTOR_WORDS = 2048,
    parameter int MEM_WORDS    = 32768,
    parameter int AW           = $clog2(MEM_WORDS),
    parameter int SW           = $clog2(SECTOR_WORDS),
    parameter int LW           = SW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [AW-1:0] cmd_offset,
    input logic [AW:0]   cmd_count,
    input logic          sub_valid,
    input logic          sub_ready,
    input logic [AW:0]   sub_byte_off,
    input logic [LW:0]   sub_byte_len,
    input logic          sub_last,
    input logic          done_valid,
    input logic [1:0]    done_status
);
    // R3: chunk never empty, never longer than a sector
    p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (sub_byte_len != '0) && (int'(sub_byte_len) <= 2*SECTOR_WORDS));

    // R3: chunk stays inside one sector
    p_no_cross_r3: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (int'(sub_byte_off[SW:1]) + int'(sub_byte_len[LW:1]) <= SECTOR_WORDS));

    // R4: byte fields are even
    p_even_r4: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> (sub_byte_off[0] == 1'b0) && (sub_byte_len[0] == 1'b0));

    // R6: offered sub-request holds until taken
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        sub_valid && !sub_ready |=> sub_valid && $stable(sub_byte_off)
                                    && $stable(sub_byte_len) && $stable(sub_last));

    // R11: no new request while a sub-request is pending
    p_busy_r11: assert property (@(posedge clk) disable iff (rst)
        sub_valid |-> !cmd_ready);

    // R8: out-of-range request answered next cycle
    p_range_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready &&
        (int'(cmd_offset) + int'(cmd_count) > MEM_WORDS)
        |=> done_valid && (done_status == 2'd1) && !sub_valid);

    // R9: zero count answered next cycle
    p_zero_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && (cmd_count == '0) &&
        (int'(cmd_offset) <= MEM_WORDS)
        |=> done_valid && (done_status == 2'd0) && !sub_valid);

    // R5: a last sub-request leads back to idle, never to another sub-request
    p_last_r5: assert property (@(posedge clk) disable iff (rst)
        sub_valid && sub_ready && sub_last |=> !sub_valid);
endmodule

bind sector_read_splitter spl_checker #(
    .SECTOR_WORDS (SECTOR_WORDS),
    .MEM_WORDS    (MEM_WORDS),
    .AW           (AW),
    .SW           (SW),
    .LW           (LW)
) u_spl_checker (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_offset   (cmd_offset),
    .cmd_count    (cmd_count),
    .sub_valid    (sub_valid),
    .sub_ready    (sub_ready),
    .sub_byte_off (sub_byte_off),
    .sub_byte_len (sub_byte_len),
    .sub_last     (sub_last),
    .done_valid   (done_valid),
    .done_status  (done_status)
);

// File: tb/sector_read_splitter_bench.sv
module sector_read_splitter_bench;
    localparam int SEC  = 16;
    localparam int MEMW = 128;
    localparam int AW   = $clog2(MEMW);
    localparam int SW   = $clog2(SEC);
    localparam int LW   = SW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_offset = '0;
    logic [AW:0]   cmd_count = '0;
    logic          sub_valid;
    logic          sub_ready = 1'b0;
    logic [AW:0]   sub_byte_off;
    logic [LW:0]   sub_byte_len;
    logic          sub_last;
    logic          ack_valid = 1'b0;
    logic          ack_err = 1'b0;
    logic          done_valid;
    logic [AW:0]   done_words;
    logic [1:0]    done_status;

    int n_tests = 0;
    int n_fail  = 0;
    logic [32:0] exp_q[$];   // {last, byte_off[15:0], byte_len[15:0]}

    always #5 clk = ~clk;

    sector_read_splitter #(.SECTOR_WORDS(SEC), .MEM_WORDS(MEMW)) u_sector_read_splitter (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_offset(cmd_offset), .cmd_count(cmd_count),
        .sub_valid(sub_valid), .sub_ready(sub_ready),
        .sub_byte_off(sub_byte_off), .sub_byte_len(sub_byte_len), .sub_last(sub_last),
        .ack_valid(ack_valid), .ack_err(ack_err),
        .done_valid(done_valid), .done_words(done_words), .done_status(done_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: each accepted sub-request is compared with the scoreboard head
    always begin
        @(negedge clk);
        #1;
        if (!rst && sub_valid && sub_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected sub-request", int'(sub_byte_off), -1);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                check(int'(sub_byte_off) == int'(e[31:16]), "R4 byte offset",
                      int'(sub_byte_off), int'(e[31:16]));
                check(int'(sub_byte_len) == int'(e[15:0]), "R2 chunk byte length",
                      int'(sub_byte_len), int'(e[15:0]));
                check(sub_last == e[32], "R5 last flag", int'(sub_last), int'(e[32]));
            end
        end
    end

    task automatic run_cmd(input int off, input int cnt, input int fail_at,
                           input int stall, input bit spur);
        int o, r, k, good, exp_st, waited;
        bit bad, failed, busy_seen;
        bad    = (off + cnt > MEMW);
        failed = 1'b0;
        good   = 0;
        if (!bad) begin
            o = off; r = cnt; k = 0;
            while (r > 0) begin
                int room, l;
                room = SEC - (o % SEC);
                l    = (r < room) ? r : room;
                exp_q.push_back({(l == r), 16'(2*o), 16'(2*l)});
                if (k == fail_at) begin failed = 1'b1; break; end
                good += l; o += l; r -= l; k++;
            end
        end
        exp_st = bad ? 1 : (failed ? 2 : 0);

        @(negedge clk);
        cmd_offset = AW'(off);
        cmd_count  = (AW+1)'(cnt);
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (bad)
            check(done_valid == 1'b1, "R8 immediate reject", int'(done_valid), 1);
        else if (cnt == 0)
            check(done_valid == 1'b1, "R9 immediate zero completion", int'(done_valid), 1);

        k = 0; waited = 0; busy_seen = 1'b0;
        while (!done_valid && waited < 3000) begin
            if (sub_valid) begin
                if (!busy_seen) begin
                    check(cmd_ready == 1'b0, "R11 busy while sequencing", int'(cmd_ready), 0);
                    busy_seen = 1'b1;
                end
                if (spur && k == 0) begin
                    ack_valid = 1'b1; ack_err = 1'b1;
                    @(negedge clk);
                    ack_valid = 1'b0; ack_err = 1'b0;
                    check(sub_valid == 1'b1, "R11 stray ack ignored", int'(sub_valid), 1);
                end
                repeat (stall) @(negedge clk);
                sub_ready = 1'b1;
                @(negedge clk);
                sub_ready = 1'b0;
                repeat (stall) @(negedge clk);
                if (stall > 0)
                    check(sub_valid == 1'b0, "R6 no issue before ack", int'(sub_valid), 0);
                ack_valid = 1'b1;
                ack_err   = (k == fail_at);
                @(negedge clk);
                ack_valid = 1'b0; ack_err = 1'b0;
                k++;
            end else begin
                @(negedge clk);
                waited++;
            end
        end
        check(done_valid == 1'b1, "R10 completion seen", int'(done_valid), 1);
        check(int'(done_words) == (bad ? 0 : good), (exp_st == 2) ? "R7 words before failure" : "R10 words done",
              int'(done_words), bad ? 0 : good);
        check(int'(done_status) == exp_st, (exp_st == 1) ? "R8 status" : ((exp_st == 2) ? "R7 status" : "R10 status"),
              int'(done_status), exp_st);
        check(exp_q.size() == 0, "R2 all chunks issued", exp_q.size(), 0);
        exp_q.delete();
        @(negedge clk);
        check(done_valid == 1'b0, "R10 single-cycle done", int'(done_valid), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R1 reset cmd_ready", int'(cmd_ready), 1);
        check(sub_valid == 1'b0, "R1 reset sub_valid", int'(sub_valid), 0);
        check(done_valid == 1'b0, "R1 reset done_valid", int'(done_valid), 0);

        run_cmd(3, 40, -1, 0, 1'b0);    // R2 unaligned start, three chunks
        run_cmd(32, 32, -1, 0, 1'b0);   // R2 aligned, full sectors
        run_cmd(5, 4, -1, 0, 1'b0);     // R5 single chunk inside sector
        run_cmd(10, 6, -1, 0, 1'b0);    // R5 ends exactly on boundary
        run_cmd(3, 40, 1, 0, 1'b0);     // R7 failure on middle chunk
        run_cmd(0, 20, 0, 0, 1'b0);     // R7 failure on first chunk
        run_cmd(120, 9, -1, 0, 1'b0);   // R8 one past the limit
        run_cmd(120, 8, -1, 0, 1'b0);   // R8 exactly at the limit
        run_cmd(7, 0, -1, 0, 1'b0);     // R9 zero count
        run_cmd(14, 20, -1, 3, 1'b1);   // R6 R11 stalls and stray ack
        run_cmd(0, 128, -1, 0, 1'b0);   // R10 whole memory

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule